// File: doc/BRIEF.md
# Monochrome NTSC Sync and Pixel Generator

The block produces a black-and-white NTSC-style composite waveform as a 2-bit level code, one code per sample. A sample tick sets the pace. At each tick the generator moves one position through a fixed line template and registers the code for that position. Off-chip resistors mix the code into the analog signal. A field is a run of picture lines, then a few vertical sync lines with double-rate pulses, then horizontal-sync-only lines with no picture. After the last of these, the field starts again.

Picture content comes from one of two 1-bit-per-sample line pattern stores. Software can rewrite one store while the other is on screen, because the store for a field is chosen when the field starts. A select input can limit the picture to a single line. A one-clock strobe marks the end of vertical sync. This opens the stretch of lines with no picture, in which the stores can be rewritten without disturbing what is displayed.

Top module: `ntsc_mono_gen`

## Requirements
- R1: Every line is exactly 473 sample ticks long. The sample index runs from 0 to 472 and the line advances after index 472.
- R2: Level codes are: 0 for sync, 1 for blank/black, and 3 for white (the blank bit 0 plus the video bit 1). The code 2 never appears.
- R3: On a picture line, samples 0–36 are sync (0) and samples 37–160 are blank (1). Samples 161–399 are white (3) when the picture is shown on that line and the selected store holds a 1 at the address equal to the sample index; otherwise they are blank. Samples 400–472 are blank.
- R4: A field is 247 picture lines, then 3 vertical sync lines, then 12 horizontal-sync-only lines, and then it repeats.
- R5: A vertical sync line is at sync (0) everywhere except samples 236–245 and samples 468–472, which are blank (1).
- R6: A horizontal-sync-only line is sync for samples 0–36 and blank for the rest. It never shows pixels, whatever the enable, select and store contents.
- R7: In a field that starts with a select value of zero, every picture line shows pixels when the video enable is 1 at that sample. When the enable is 0, the line is blank.
- R8: In a field that starts with a nonzero select value, only picture line n of the field shows pixels, where n is the live select value and lines are counted from 1. In this mode the video enable has no effect.
- R9: The flip input is sampled on the tick that leaves the last horizontal-sync-only line. Store 0 is used for the field when flip is 0, and store 1 when flip is 1.
- R10: The window strobe is high for exactly one clock, in the clock after the tick that ends the last vertical sync line. It pulses once per field.
- R11: Stores are written through a write-enable, store-select, address and data port in one clock. The level output changes only in the clock after a tick. A write and a display read in the same clock return the old bit.
- R12: While reset is active and right after it, the level is 0 and the strobe is 0. The first tick after reset emits sample 0 of picture line 1 in all-lines mode, using store 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Sample tick, one sample per clock in which it is high |
| vid_en | input | 1 | Video enable for all-lines mode |
| line_sel | input | LW (9) | Single-line select; zero means all lines |
| flip | input | 1 | Store choice for the next field |
| pix_wr_en | input | 1 | Store write enable |
| pix_wr_buf | input | 1 | Store selected for the write |
| pix_wr_addr | input | AW (9) | Write address, equal to the sample index |
| pix_wr_data | input | 1 | Pixel bit to write |
| level | output | 2 | Level code (0 sync, 1 blank, 3 white) |
| win_strobe | output | 1 | One-clock pulse when vertical sync ends |

## Verification
The bench shrinks the picture-line count to 8 so that four whole fields fit in the run. The line template stays at its full size. The fields are run in four setups: all-lines mode with the enable toggled line by line, single-line mode on line 3 with the enable held low, all-lines mode with the enable low, and single-line mode on the last picture line. The flip value differs between fields. Together these show apart enable gating, single-line selection, the latching of the mode at field start, and which store is being read. Random tick gaps show that the output holds between ticks, and random store writes during display test the old-data read rule.

// File: rtl/ntsc_pkg.sv
package ntsc_pkg;
  typedef enum logic [2:0] {
    M_VID_ALL = 3'd0,
    M_VID_ONE = 3'd1,
    M_VSYNC   = 3'd2,
    M_POST    = 3'd3
  } mode_e;

  typedef enum logic [1:0] {
    C_SYNC  = 2'd0,
    C_BLANK = 2'd1,
    C_PIX   = 2'd2
  } cls_e;

  localparam logic [1:0] LVL_SYNC  = 2'b00;
  localparam logic [1:0] LVL_BLANK = 2'b01;
  localparam logic [1:0] LVL_WHITE = 2'b11;
endpackage

// File: rtl/ntsc_line_seq.sv
module ntsc_line_seq
  import ntsc_pkg::*;
#(
  parameter int LINE_LEN   = 473,
  parameter int VID_LINES  = 247,
  parameter int VS_LINES   = 3,
  parameter int POST_LINES = 12,
  parameter int SW         = 9,
  parameter int LW         = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic [LW-1:0] line_sel,
  input  logic          flip,
  output mode_e         mode,
  output logic [LW-1:0] line,
  output logic [SW-1:0] samp,
  output logic          buf_sel,
  output logic          win_strobe
);
  int  lim;
  logic eol, last_line;

  always_comb begin
    case (mode)
      M_VID_ALL, M_VID_ONE: lim = VID_LINES;
      M_VSYNC:              lim = VS_LINES;
      M_POST:               lim = POST_LINES;
      default:              lim = 1;
    endcase
  end

  assign eol       = (int'(samp) == LINE_LEN - 1);
  assign last_line = (int'(line) == lim - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode       <= M_VID_ALL;
      line       <= '0;
      samp       <= '0;
      buf_sel    <= 1'b0;
      win_strobe <= 1'b0;
    end else begin
      win_strobe <= 1'b0;
      case (mode)
        M_VID_ALL, M_VID_ONE, M_VSYNC, M_POST: begin
          if (tick) begin
            if (eol) begin
              samp <= '0;
              if (last_line) begin
                line <= '0;
                case (mode)
                  M_VSYNC: begin
                    mode       <= M_POST;
                    win_strobe <= 1'b1;
                  end
                  M_POST: begin
                    mode    <= (line_sel != '0) ? M_VID_ONE : M_VID_ALL;
                    buf_sel <= flip;
                  end
                  default: mode <= M_VSYNC;
                endcase
              end else begin
                line <= line + LW'(1);
              end
            end else begin
              samp <= samp + SW'(1);
            end
          end
        end
        default: begin
          mode    <= M_VID_ALL;
          line    <= '0;
          buf_sel <= 1'b0;
        end
      endcase
    end
  end

  assert_samp_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    int'(samp) < LINE_LEN);

  assert_line_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    int'(line) < lim);

  assert_strobe_once_R10: assert property (@(posedge clk) disable iff (!rst_n)
    win_strobe |=> !win_strobe);

  assert_strobe_place_R10: assert property (@(posedge clk) disable iff (!rst_n)
    win_strobe |-> (mode == M_POST && line == '0 && samp == '0));

  assert_buf_at_field_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_sel != $past(buf_sel)) |-> ($past(mode) == M_POST && line == '0 && samp == '0));
endmodule

// File: rtl/ntsc_tmpl.sv
module ntsc_tmpl
  import ntsc_pkg::*;
#(
  parameter int LINE_LEN     = 473,
  parameter int SYNC_END     = 37,
  parameter int PIX_AFTER    = 160,
  parameter int ACT_END      = 400,
  parameter int VS_PULSE_AT  = 236,
  parameter int VS_PULSE_LEN = 10,
  parameter int VS_TAIL      = 5,
  parameter int SW           = 9,
  parameter int LW           = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  mode_e         mode,
  input  logic [LW-1:0] line,
  input  logic [SW-1:0] samp,
  input  logic          vid_en,
  input  logic [LW-1:0] line_sel,
  output cls_e          cls_q
);
  int   s;
  logic show;
  cls_e cls_d;

  assign s = int'(samp);

  always_comb begin
    show  = (mode == M_VID_ALL) ? vid_en : (line_sel == line + LW'(1));
    cls_d = C_SYNC;
    case (mode)
      M_VID_ALL, M_VID_ONE: begin
        if (s < SYNC_END)                               cls_d = C_SYNC;
        else if (show && s > PIX_AFTER && s < ACT_END)  cls_d = C_PIX;
        else                                            cls_d = C_BLANK;
      end
      M_VSYNC: begin
        if ((s >= VS_PULSE_AT && s < VS_PULSE_AT + VS_PULSE_LEN) ||
            s >= LINE_LEN - VS_TAIL)                    cls_d = C_BLANK;
        else                                            cls_d = C_SYNC;
      end
      M_POST:  cls_d = (s < SYNC_END) ? C_SYNC : C_BLANK;
      default: cls_d = C_SYNC;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    cls_q <= C_SYNC;
    else if (tick) cls_q <= cls_d;
  end

  assert_no_pix_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && (mode == M_VSYNC || mode == M_POST)) |=> (cls_q != C_PIX));
endmodule

// File: rtl/ntsc_pix_store.sv
module ntsc_pix_store #(
  parameter int DEPTH = 512,
  parameter int AW    = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          wr_en,
  input  logic          wr_buf,
  input  logic [AW-1:0] wr_addr,
  input  logic          wr_data,
  input  logic          rd_buf,
  input  logic [AW-1:0] rd_addr,
  output logic          pix_q
);
  logic [1:0] rd_bit;

  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic mem [DEPTH];
    always_ff @(posedge clk) begin
      if (wr_en && (wr_buf == 1'(b))) mem[wr_addr] <= wr_data;
    end
    assign rd_bit[b] = mem[rd_addr];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    pix_q <= 1'b0;
    else if (tick) pix_q <= rd_bit[rd_buf];
  end
endmodule

// File: rtl/ntsc_mono_gen.sv
module ntsc_mono_gen
  import ntsc_pkg::*;
#(
  parameter int LINE_LEN     = 473,
  parameter int SYNC_END     = 37,
  parameter int PIX_AFTER    = 160,
  parameter int ACT_END      = 400,
  parameter int VS_PULSE_AT  = 236,
  parameter int VS_PULSE_LEN = 10,
  parameter int VS_TAIL      = 5,
  parameter int VID_LINES    = 247,
  parameter int VS_LINES     = 3,
  parameter int POST_LINES   = 12,
  parameter int STORE_DEPTH  = 512,
  parameter int LW = $clog2(VID_LINES + VS_LINES + POST_LINES + 1),
  parameter int AW = $clog2(STORE_DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          vid_en,
  input  logic [LW-1:0] line_sel,
  input  logic          flip,
  input  logic          pix_wr_en,
  input  logic          pix_wr_buf,
  input  logic [AW-1:0] pix_wr_addr,
  input  logic          pix_wr_data,
  output logic [1:0]    level,
  output logic          win_strobe
);
  localparam int SW = $clog2(LINE_LEN);

  mode_e         mode;
  logic [LW-1:0] line;
  logic [SW-1:0] samp;
  logic          buf_sel;
  cls_e          cls_q;
  logic          pix_q;

  ntsc_line_seq #(
    .LINE_LEN(LINE_LEN), .VID_LINES(VID_LINES), .VS_LINES(VS_LINES),
    .POST_LINES(POST_LINES), .SW(SW), .LW(LW)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .tick(tick), .line_sel(line_sel), .flip(flip),
    .mode(mode), .line(line), .samp(samp), .buf_sel(buf_sel),
    .win_strobe(win_strobe)
  );

  ntsc_tmpl #(
    .LINE_LEN(LINE_LEN), .SYNC_END(SYNC_END), .PIX_AFTER(PIX_AFTER),
    .ACT_END(ACT_END), .VS_PULSE_AT(VS_PULSE_AT), .VS_PULSE_LEN(VS_PULSE_LEN),
    .VS_TAIL(VS_TAIL), .SW(SW), .LW(LW)
  ) u_tmpl (
    .clk(clk), .rst_n(rst_n), .tick(tick), .mode(mode), .line(line),
    .samp(samp), .vid_en(vid_en), .line_sel(line_sel), .cls_q(cls_q)
  );

  ntsc_pix_store #(.DEPTH(STORE_DEPTH), .AW(AW)) u_store (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .wr_en(pix_wr_en), .wr_buf(pix_wr_buf), .wr_addr(pix_wr_addr),
    .wr_data(pix_wr_data), .rd_buf(buf_sel), .rd_addr(AW'(samp)),
    .pix_q(pix_q)
  );

  always_comb begin
    if (cls_q == C_SYNC)             level = LVL_SYNC;
    else if (cls_q == C_PIX && pix_q) level = LVL_WHITE;
    else                             level = LVL_BLANK;
  end

  assert_no_code2_R2: assert property (@(posedge clk) disable iff (!rst_n)
    level != 2'b10);

  assert_hold_between_ticks_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(level));
endmodule

// File: tb/tb_ntsc_mono_gen.sv
module tb_ntsc_mono_gen;
  localparam int LL = 473;
  localparam int VL = 8;
  localparam int VS = 3;
  localparam int PL = 12;
  localparam int LW = $clog2(VL + VS + PL + 1);

  logic clk = 1'b0;
  logic rst_n, tick, vid_en, flip, wr_en, wr_buf, wr_data, strobe;
  logic [LW-1:0] sel;
  logic [8:0] wr_addr;
  logic [1:0] level;

  always #5 clk = ~clk;

  ntsc_mono_gen #(.VID_LINES(VL)) dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .vid_en(vid_en), .line_sel(sel),
    .flip(flip), .pix_wr_en(wr_en), .pix_wr_buf(wr_buf), .pix_wr_addr(wr_addr),
    .pix_wr_data(wr_data), .level(level), .win_strobe(strobe)
  );

  int n_cmp = 0, n_bad = 0;
  bit mem_m [2][512];
  int m_mode, m_line, m_samp, m_buf, field;
  int exp_level, exp_strobe;
  string exp_tag;

  task automatic chk(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int lvl_of(int md, int ln, int s, bit px, bit en, int sl);
    bit show;
    if (md <= 1) begin
      if (s < 37) return 0;
      show = (md == 0) ? en : (sl == ln + 1);
      return (show && s > 160 && s < 400 && px) ? 3 : 1;
    end else if (md == 2) begin
      return ((s >= 236 && s < 246) || s >= 468) ? 1 : 0;
    end
    return (s < 37) ? 0 : 1;
  endfunction

  function automatic string tag_of(int md, int s);
    if (md == 2) return "R4/R5/R2";
    if (md == 3) return "R4/R6/R2";
    if (s < 161 || s >= 400) return "R1/R3/R2";
    return (md == 0) ? "R7/R9/R11/R3" : "R8/R9/R11/R3";
  endfunction

  initial begin
    int seed;
    seed = $urandom(32'd20251);
    rst_n = 0; tick = 0; vid_en = 1; flip = 0; sel = '0;
    wr_en = 0; wr_buf = 0; wr_addr = '0; wr_data = 0;
    for (int b = 0; b < 2; b++) begin
      for (int a = 0; a < 512; a++) begin
        @(negedge clk);
        wr_en = 1; wr_buf = 1'(b); wr_addr = 9'(a); wr_data = 1'($urandom % 2);
        mem_m[b][a] = wr_data;
      end
    end
    @(negedge clk);
    wr_en = 0;
    @(negedge clk);
    chk("R12 level in reset", int'(level), 0);
    chk("R12 strobe in reset", int'(strobe), 0);
    rst_n = 1;
    m_mode = 0; m_line = 0; m_samp = 0; m_buf = 0; field = 0;
    exp_level = 0; exp_strobe = 0; exp_tag = "R12";
    while (field < 4) begin
      @(negedge clk);
      chk(exp_tag, int'(level), exp_level);
      chk("R10 strobe", int'(strobe), exp_strobe);
      tick = ($urandom % 4) != 0;
      wr_en = ($urandom % 3) == 0;
      wr_buf = 1'($urandom % 2);
      wr_addr = 9'($urandom % 512);
      wr_data = 1'($urandom % 2);
      exp_strobe = 0;
      if (tick) begin
        if (field == 0 && m_mode == 0 && m_samp == 0) vid_en = ($urandom % 4) != 0;
        exp_level = lvl_of(m_mode, m_line, m_samp, mem_m[m_buf][m_samp], vid_en, int'(sel));
        exp_tag = tag_of(m_mode, m_samp);
        if (m_samp == LL - 1) begin
          m_samp = 0;
          if (m_mode <= 1 && m_line == VL - 1) begin
            m_line = 0; m_mode = 2;
            case (field)
              0: begin flip = 1; sel = LW'(3); vid_en = 0; end
              1: begin flip = 0; sel = '0;     vid_en = 0; end
              2: begin flip = 1; sel = LW'(VL); vid_en = 1; end
              default: ;
            endcase
            field++;
          end else if (m_mode == 2 && m_line == VS - 1) begin
            m_line = 0; m_mode = 3; exp_strobe = 1;
          end else if (m_mode == 3 && m_line == PL - 1) begin
            m_line = 0; m_mode = (sel != '0) ? 1 : 0; m_buf = int'(flip);
          end else begin
            m_line++;
          end
        end else begin
          m_samp++;
        end
      end
      if (wr_en) mem_m[wr_buf][wr_addr] = wr_data;
    end
    @(negedge clk);
    tick = 0; wr_en = 0;
    chk(exp_tag, int'(level), exp_level);
    chk("R10 strobe", int'(strobe), exp_strobe);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule